// File: doc/BRIEF.md
# DMA Channel Event and Interrupt Unit

This block sits beside the transfer engine of one DMA channel. It watches the engine's status signals and records five kinds of event in sticky flags: full completion, half completion, bus access error, single-data exception, and a combined FIFO error/exception. Software clears the flags with write-one-to-clear strobes. Each flag is gated by its own enable bit, and the enabled flags are ORed into a single channel interrupt line.

The events fall into three classes. Completion flags only report progress. Exceptions are recorded while the transfer carries on. Errors are recorded and also produce a one-cycle stop request that halts the engine. The full-completion rule depends on which side controls the flow and on the transfer direction. When the DMA controls the flow, the count running out ends the transfer. When the peripheral controls the flow, the transfer ends at the last peripheral request, and in peripheral-to-memory mode also only once the FIFO has drained. A software disable ends the transfer once the accesses already in flight finish, and, when data moves through the FIFO into memory, once the FIFO has drained.

Top module: `dma_chan_evt`

## Requirements
- R1: After reset, `flags` is 0, `irq` is 0 and `stop_req` is 0.
- R2: With DMA flow control (`flow_per`=0), a `beat` carrying `rem_cnt`=0 during an active transfer sets flag bit 0 (full) on the next clock. The transfer then ends.
- R3: Flag bit 1 (half) is set on the first `beat` of a transfer whose `rem_cnt` equals `prog_cnt`>>1. A later beat with that same value in the same transfer does not set it again.
- R4: With peripheral flow control and `dir`=2'b00 (peripheral to memory), `last_req_done` sets flag bit 0 only when `fifo_empty` is high. While the FIFO is not empty, completion waits.
- R5: With peripheral flow control and `dir`=2'b01 (memory to peripheral), `last_req_done` sets flag bit 0 on the next clock, whatever `fifo_empty` is.
- R6: After `sw_disable`, flag bit 0 is set once `inflight_done` has been seen. For `dir`=2'b00 or 2'b10 (memory to memory), `fifo_empty` must also be high. For `dir`=2'b01, the FIFO is not waited on.
- R7: Flags are sticky until their `clr` bit is pulsed. When an event and the clear of the same bit occur on the same cycle, the flag stays set.
- R8: `irq` is high exactly when some flag bit and the matching `ie` bit are both set.
- R9: `acc_err` or `fifo_err` during an active transfer sets its flag (bit 2 or bit 4). It also raises `stop_req` for exactly one cycle, on the next clock, and the transfer ends with no full flag.
- R10: `sd_exc` sets flag bit 3 without raising `stop_req`. The transfer continues to its normal full completion.
- R11: `fifo_exc` and `fifo_err` share flag bit 4. Only `fifo_err` raises `stop_req`.
- R12: An error input while no transfer is active sets its flag but raises no `stop_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse: the engine begins a transfer |
| flow_per | input | 1 | 1: the peripheral controls the flow; 0: the DMA does |
| dir | input | 2 | 00 peripheral-to-memory, 01 memory-to-peripheral, 10 memory-to-memory |
| prog_cnt | input | CNT_W | Programmed item count of the transfer |
| rem_cnt | input | CNT_W | Remaining item count, valid with `beat` |
| beat | input | 1 | Pulse: one item transferred |
| last_req_done | input | 1 | Pulse: the peripheral's last request has been served |
| fifo_empty | input | 1 | The FIFO holds no data |
| sw_disable | input | 1 | Pulse: software disabled the channel |
| inflight_done | input | 1 | Pulse: in-flight accesses after a disable are complete |
| acc_err | input | 1 | Bus access error |
| sd_exc | input | 1 | Single-data mode exception |
| fifo_err | input | 1 | FIFO error |
| fifo_exc | input | 1 | FIFO exception |
| ie | input | 5 | Interrupt enable per flag bit |
| clr | input | 5 | Write-one-to-clear strobes per flag bit |
| flags | output | 5 | Sticky flags: 0 full, 1 half, 2 access error, 3 single-data exception, 4 FIFO error/exception |
| irq | output | 1 | Channel interrupt |
| stop_req | output | 1 | One-cycle stop request to the engine |

## Verification
The assertions assume that the engine raises `start` only while the channel is idle. They also assume that `dir` and `flow_per` are held for the whole transfer, and that `inflight_done` comes only after a disable. The stop-pulse checks rely on no error input being high on two consecutive cycles of one active transfer. The directed tasks meet these assumptions: each one drives a single transfer to its end before the next begins, holds the mode inputs stable throughout, and pulses every event input for one cycle.

// File: rtl/dma_evt_pkg.sv
// Package: shared constants and types for the DMA channel event unit.
// Assumes: flag bit order is fixed because software decodes it.
package dma_evt_pkg;
    localparam int EVT_N = 5;

    localparam int EV_FULL = 0;
    localparam int EV_HALF = 1;
    localparam int EV_ACC  = 2;
    localparam int EV_SDE  = 3;
    localparam int EV_FIFO = 4;

    localparam logic [1:0] DIR_P2M = 2'b00;
    localparam logic [1:0] DIR_M2P = 2'b01;
    localparam logic [1:0] DIR_M2M = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT_FIFO,
        ST_WAIT_DIS
    } xfer_st_e;
endpackage

// File: rtl/dma_evt_finish.sv
// Module: tracks one transfer and decides when the full and half completion
// events fire.
// Assumes: dir and flow_per stay stable during a transfer; start comes only
// when idle; halt is the error stop from dma_evt_stop.
module dma_evt_finish
    import dma_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             flow_per,
    input  logic [1:0]       dir,
    input  logic [CNT_W-1:0] prog_cnt,
    input  logic [CNT_W-1:0] rem_cnt,
    input  logic             beat,
    input  logic             last_req_done,
    input  logic             fifo_empty,
    input  logic             sw_disable,
    input  logic             inflight_done,
    input  logic             halt,
    output logic             full_evt,
    output logic             half_evt,
    output logic             active
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    xfer_st_e   st_q, st_d;
    logic       half_done_q;
    logic       infl_seen_q;
    logic [CNT_W-1:0] half_mark;
    logic       fifo_ok_dis;

    assign half_mark   = prog_cnt >> 1;
    assign active      = (st_q != ST_IDLE);
    assign fifo_ok_dis = (dir == DIR_M2P) || fifo_empty;

    // Next-state and event decode of the transfer tracker.
    always_comb begin
        st_d     = st_q;
        full_evt = 1'b0;
        half_evt = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (halt) begin
                    st_d = ST_IDLE;
                end else begin
                    half_evt = beat && (rem_cnt == half_mark) && !half_done_q;
                    if (!flow_per && beat && (rem_cnt == CNT_ZERO)) begin
                        full_evt = 1'b1;
                        st_d     = ST_IDLE;
                    end else if (flow_per && last_req_done) begin
                        if ((dir != DIR_P2M) || fifo_empty) begin
                            full_evt = 1'b1;
                            st_d     = ST_IDLE;
                        end else begin
                            st_d = ST_WAIT_FIFO;
                        end
                    end else if (sw_disable) begin
                        st_d = ST_WAIT_DIS;
                    end
                end
            end
            ST_WAIT_FIFO: begin
                if (halt) begin
                    st_d = ST_IDLE;
                end else if (fifo_empty) begin
                    full_evt = 1'b1;
                    st_d     = ST_IDLE;
                end
            end
            ST_WAIT_DIS: begin
                if (halt) begin
                    st_d = ST_IDLE;
                end else if ((inflight_done || infl_seen_q) && fifo_ok_dis) begin
                    full_evt = 1'b1;
                    st_d     = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register of the transfer tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Remembers that half completion already fired in this transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                       half_done_q <= 1'b0;
        else if (st_q == ST_IDLE && start) half_done_q <= 1'b0;
        else if (half_evt)                half_done_q <= 1'b1;
    end

    // Remembers in-flight completion while waiting for the FIFO after a disable.
    always_ff @(posedge clk) begin
        if (!rst_n)                    infl_seen_q <= 1'b0;
        else if (st_q != ST_WAIT_DIS)  infl_seen_q <= 1'b0;
        else if (inflight_done)        infl_seen_q <= 1'b1;
    end

    AST_FULL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        full_evt |=> !active); // R2
    AST_HALF_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        half_evt |=> !half_evt); // R3
    AST_FIFO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_FIFO && !fifo_empty) |-> !full_evt); // R4
    AST_HALT_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !full_evt); // R9
endmodule

// File: rtl/dma_evt_stop.sv
// Module: turns an error during an active transfer into a one-cycle stop request.
// Assumes: error inputs are not high on consecutive cycles of one transfer.
module dma_evt_stop (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic acc_err,
    input  logic fifo_err,
    output logic halt,
    output logic stop_req
);
    assign halt = active && (acc_err || fifo_err);

    // Registers the stop request one cycle after the error.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_req <= 1'b0;
        else        stop_req <= halt;
    end

    AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !stop_req); // R9
    AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> $past(acc_err || fifo_err)); // R9
    AST_IDLE_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !stop_req); // R12
endmodule

// File: rtl/dma_evt_flags.sv
// Module: sticky event flags with write-one-to-clear and the masked interrupt.
// Assumes: evt bits are single-cycle or level; a set on the same cycle as a clear wins.
module dma_evt_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flags,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag: set by its event, cleared by its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (evt[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i]) |=> flags[i]); // R7
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flags[i]); // R7
    end

    assign irq = |(flags & ie);

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == '0) |-> !irq); // R8
endmodule

// File: rtl/dma_chan_evt.sv
// Module: top of the DMA channel event and interrupt unit.
// Assumes: inputs come from one channel's transfer engine, synchronous to clk.
module dma_chan_evt
    import dma_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             flow_per,
    input  logic [1:0]       dir,
    input  logic [CNT_W-1:0] prog_cnt,
    input  logic [CNT_W-1:0] rem_cnt,
    input  logic             beat,
    input  logic             last_req_done,
    input  logic             fifo_empty,
    input  logic             sw_disable,
    input  logic             inflight_done,
    input  logic             acc_err,
    input  logic             sd_exc,
    input  logic             fifo_err,
    input  logic             fifo_exc,
    input  logic [4:0]       ie,
    input  logic [4:0]       clr,
    output logic [4:0]       flags,
    output logic             irq,
    output logic             stop_req
);
    logic             full_evt;
    logic             half_evt;
    logic             active;
    logic             halt;
    logic [EVT_N-1:0] evt;

    dma_evt_finish #(.CNT_W(CNT_W)) u_finish (
        .clk(clk), .rst_n(rst_n), .start(start), .flow_per(flow_per), .dir(dir),
        .prog_cnt(prog_cnt), .rem_cnt(rem_cnt), .beat(beat),
        .last_req_done(last_req_done), .fifo_empty(fifo_empty),
        .sw_disable(sw_disable), .inflight_done(inflight_done), .halt(halt),
        .full_evt(full_evt), .half_evt(half_evt), .active(active)
    );

    dma_evt_stop u_stop (
        .clk(clk), .rst_n(rst_n), .active(active), .acc_err(acc_err),
        .fifo_err(fifo_err), .halt(halt), .stop_req(stop_req)
    );

    // Gathers the five event sources into flag order.
    always_comb begin
        evt          = '0;
        evt[EV_FULL] = full_evt;
        evt[EV_HALF] = half_evt;
        evt[EV_ACC]  = acc_err;
        evt[EV_SDE]  = sd_exc;
        evt[EV_FIFO] = fifo_err || fifo_exc;
    end

    dma_evt_flags #(.N(EVT_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr), .ie(ie),
        .flags(flags), .irq(irq)
    );

    AST_EXC_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ((sd_exc || fifo_exc) && !acc_err && !fifo_err) |=> !stop_req); // R10
    AST_EXC_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sd_exc && !acc_err && !fifo_err && !beat && !last_req_done
         && !sw_disable) |=> active); // R10
endmodule

// File: tb/sim_dma_chan_evt.sv
module sim_dma_chan_evt;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 0, flow_per = 0, beat = 0, last_req_done = 0;
    logic          fifo_empty = 1, sw_disable = 0, inflight_done = 0;
    logic          acc_err = 0, sd_exc = 0, fifo_err = 0, fifo_exc = 0;
    logic [1:0]    dir = 2'b00;
    logic [CW-1:0] prog_cnt = '0, rem_cnt = '0;
    logic [4:0]    ie = '0, clr = '0;
    logic [4:0]    flags;
    logic          irq, stop_req;
    int            n_chk = 0, n_fail = 0;
    logic          fin = 1'b0;

    always #2 clk = ~clk;

    dma_chan_evt #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .flow_per(flow_per), .dir(dir),
        .prog_cnt(prog_cnt), .rem_cnt(rem_cnt), .beat(beat),
        .last_req_done(last_req_done), .fifo_empty(fifo_empty),
        .sw_disable(sw_disable), .inflight_done(inflight_done),
        .acc_err(acc_err), .sd_exc(sd_exc), .fifo_err(fifo_err),
        .fifo_exc(fifo_exc), .ie(ie), .clr(clr), .flags(flags), .irq(irq),
        .stop_req(stop_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_all();
        clr = 5'h1F; step(); clr = '0; step();
    endtask

    task automatic begin_xfer(input logic fp, input logic [1:0] d, input int cnt);
        flow_per = fp; dir = d; prog_cnt = CW'(cnt);
        start = 1; step(); start = 0;
    endtask

    task automatic do_beat(input int rem);
        rem_cnt = CW'(rem); beat = 1; step(); beat = 0;
    endtask

    task automatic t_reset();
        chk("R1 flags", 32'(flags), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 stop", 32'(stop_req), 0);
    endtask

    task automatic t_dma_flow();
        clear_all();
        begin_xfer(0, 2'b10, 4);
        do_beat(3);
        chk("R3 half early", 32'(flags[1]), 0);
        do_beat(2);
        chk("R3 half set", 32'(flags[1]), 1);
        clr = 5'b00010; step(); clr = '0;
        do_beat(2);
        chk("R3 half once", 32'(flags[1]), 0);
        do_beat(1);
        chk("R2 full early", 32'(flags[0]), 0);
        do_beat(0);
        chk("R2 full set", 32'(flags[0]), 1);
    endtask

    task automatic t_sticky();
        repeat (3) step();
        chk("R7 sticky", 32'(flags[0]), 1);
        clr = 5'b00001; step(); clr = '0;
        chk("R7 w1c", 32'(flags[0]), 0);
        sd_exc = 1; clr = 5'b01000; step(); sd_exc = 0; clr = '0;
        chk("R7 set wins", 32'(flags[3]), 1);
    endtask

    task automatic t_irq();
        ie = 5'b00000; #1;
        chk("R8 masked", 32'(irq), 0);
        ie = 5'b00001; #1;
        chk("R8 other bit", 32'(irq), 0);
        ie = 5'b01000; #1;
        chk("R8 enabled", 32'(irq), 1);
        step();
        clr = 5'b01000; step(); clr = '0;
        chk("R8 cleared", 32'(irq), 0);
        ie = '0;
    endtask

    task automatic t_per_p2m();
        clear_all();
        fifo_empty = 0;
        begin_xfer(1, 2'b00, 8);
        last_req_done = 1; step(); last_req_done = 0;
        chk("R4 wait fifo", 32'(flags[0]), 0);
        repeat (3) step();
        chk("R4 still wait", 32'(flags[0]), 0);
        fifo_empty = 1; step();
        chk("R4 drained", 32'(flags[0]), 1);
    endtask

    task automatic t_per_m2p();
        clear_all();
        fifo_empty = 0;
        begin_xfer(1, 2'b01, 8);
        last_req_done = 1; step(); last_req_done = 0;
        chk("R5 full", 32'(flags[0]), 1);
        fifo_empty = 1;
    endtask

    task automatic t_disable();
        clear_all();
        fifo_empty = 0;
        begin_xfer(0, 2'b10, 8);
        sw_disable = 1; step(); sw_disable = 0;
        inflight_done = 1; step(); inflight_done = 0;
        chk("R6 fifo pending", 32'(flags[0]), 0);
        fifo_empty = 1; step();
        chk("R6 full m2m", 32'(flags[0]), 1);
        clear_all();
        fifo_empty = 0;
        begin_xfer(0, 2'b01, 8);
        sw_disable = 1; step(); sw_disable = 0;
        chk("R6 infl pending", 32'(flags[0]), 0);
        inflight_done = 1; step(); inflight_done = 0;
        chk("R6 full m2p", 32'(flags[0]), 1);
        fifo_empty = 1;
    endtask

    task automatic t_error();
        clear_all();
        begin_xfer(0, 2'b00, 4);
        do_beat(3);
        acc_err = 1; step(); acc_err = 0;
        chk("R9 acc flag", 32'(flags[2]), 1);
        chk("R9 stop pulse", 32'(stop_req), 1);
        step();
        chk("R9 stop single", 32'(stop_req), 0);
        do_beat(0);
        chk("R9 halted", 32'(flags[0]), 0);
    endtask

    task automatic t_exception();
        clear_all();
        begin_xfer(0, 2'b00, 4);
        sd_exc = 1; step(); sd_exc = 0;
        chk("R10 sde flag", 32'(flags[3]), 1);
        chk("R10 no stop", 32'(stop_req), 0);
        fifo_exc = 1; step(); fifo_exc = 0;
        chk("R11 fifo exc flag", 32'(flags[4]), 1);
        chk("R11 exc no stop", 32'(stop_req), 0);
        do_beat(0);
        chk("R10 continues", 32'(flags[0]), 1);
        clear_all();
        begin_xfer(0, 2'b00, 4);
        fifo_err = 1; step(); fifo_err = 0;
        chk("R11 fifo err flag", 32'(flags[4]), 1);
        chk("R11 err stops", 32'(stop_req), 1);
    endtask

    task automatic t_idle_err();
        clear_all();
        acc_err = 1; step(); acc_err = 0;
        chk("R12 flag", 32'(flags[2]), 1);
        chk("R12 no stop", 32'(stop_req), 0);
        step();
        chk("R12 still none", 32'(stop_req), 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1; step();
        t_reset();
        t_dma_flow();
        t_sticky();
        t_irq();
        t_per_p2m();
        t_per_m2p();
        t_disable();
        t_error();
        t_exception();
        t_idle_err();
        fin = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule